// File: doc/BRIEF.md
# RTC Periodic Tick Rate Divider

This block turns a 32.768 kHz reference into a programmable periodic tick for the interrupt unit of a real-time clock. The reference enters as a one-cycle enable strobe already in the system clock domain. A free-running 15-bit counter advances on each strobe. A tick pulse, one system clock wide, is produced whenever the counter crosses a boundary of the selected period. Each tick is the event that sets the periodic flag downstream. The flag is set whether or not the periodic interrupt is enabled; that masking lives outside this block.

Software programs an 8-bit configuration byte. Its low nibble is a rate code. Code 0 turns the tick off. Code n from 1 to 15 gives 2^(16-n) Hz, so larger codes mean slower ticks. A three-bit reference-select field must hold the 32.768 kHz code before the counter runs. Changing the rate never restarts the counter, so the tick stays in phase with the running count and no stray pulse appears when the rate changes. Reset brings the block up at 1024 Hz.

Top module: `rtc_rate_div`

## Requirements
- R1: After reset, cfgQ reads 8'h26, tickOut is 0 and the counter is zero. The value 8'h26 means rate code 6 and reference select 3'b010.
- R2: A cycle with cfgWe high loads cfgData into the byte. The change is visible on cfgQ from the next cycle. Bits 3:0 hold the rate code and bits 6:4 hold the reference select. Bit 7 always reads 0, and writes to it are ignored.
- R3: With rate code 0, tickOut never rises, but the counter keeps advancing on each strobe.
- R4: With rate code n (1 to 15), a tick follows every strobe that brings the strobe count since the counter was last zero to a multiple of 2^(n-1). That gives 2^(16-n) Hz from 32.768 kHz: code 1 ticks on every strobe, code 6 on every 32nd strobe (1024 Hz), and code 15 on every 16384th strobe (2 Hz).
- R5: tickOut is high for exactly one cycle, in the cycle after the strobe that caused it. It never rises without a strobe in the cycle before.
- R6: The counter advances only on a strobe while reference select is 3'b010. Any other value holds the counter at zero and stops all ticks. After the field returns to 3'b010, counting restarts from zero.
- R7: Writing a new rate code does not touch the counter and does not produce a pulse. The next tick comes at the next boundary of the new period on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refStb | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| cfgWe | input | 1 | Write enable for the configuration byte |
| cfgData | input | 8 | Configuration byte to write |
| cfgQ | output | 8 | Current configuration byte |
| tickOut | output | 1 | One-cycle periodic tick |

## Verification
The assertions take for granted that refStb and cfgWe carry known values once reset is released. They place no limit on how often strobes arrive, so the counter-step and hold properties hold even for back-to-back strobes. The stimulus separates strobes by two idle cycles, so a tick can be checked as one cycle wide and as tied to its own strobe. It never issues a write in a strobe cycle, so each rate change falls cleanly between two counter steps.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  parameter int CNT_W  = 15;
  parameter int RATE_W = 4;
  parameter int DSEL_W = 3;
  parameter int CFG_W  = 8;
  parameter logic [DSEL_W-1:0] DSEL_RUN = 3'b010;
  parameter logic [RATE_W-1:0] RATE_RST = 4'd6;

  typedef struct packed {
    logic              run;
    logic [RATE_W-1:0] rate;
  } divCtrl_t;
endpackage

// File: rtl/rtc_rate_ctrl.sv
module rtc_rate_ctrl
  import rtc_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  output logic [CFG_W-1:0] cfgQ,
  output divCtrl_t         ctrl
);
  localparam int DSEL_LO = RATE_W;
  localparam int DSEL_HI = RATE_W + DSEL_W - 1;
  localparam int PAD_W   = CFG_W - RATE_W - DSEL_W;

  logic [RATE_W-1:0] rateQ;
  logic [DSEL_W-1:0] dselQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= RATE_RST;
      dselQ <= DSEL_RUN;
    end else if (cfgWe) begin
      rateQ <= cfgData[RATE_W-1:0];
      dselQ <= cfgData[DSEL_HI:DSEL_LO];
    end
  end

  assign cfgQ     = {{PAD_W{1'b0}}, dselQ, rateQ};
  assign ctrl.run  = (dselQ == DSEL_RUN);
  assign ctrl.rate = rateQ;

  // R2: top bit never set
  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[CFG_W-1] == 1'b0);
  // R2: byte holds without a write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgQ));
endmodule

// File: rtl/rtc_rate_dp.sv
module rtc_rate_dp
  import rtc_rate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     refStb,
  input  divCtrl_t ctrl,
  output logic     tickOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tapMask;
  logic             fire;

  always_comb begin
    if (ctrl.rate == '0) tapMask = '0;
    else tapMask = (CNT_W'(1) << (ctrl.rate - RATE_W'(1))) - CNT_W'(1);
    fire = ctrl.run && refStb && (ctrl.rate != '0) &&
           ((cnt & tapMask) == tapMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      tickOut <= 1'b0;
    end else begin
      tickOut <= fire;
      if (!ctrl.run) cnt <= '0;
      else if (refStb) cnt <= cnt + CNT_W'(1);
    end
  end

  // R5: a tick always follows a strobe
  p_tick_after_stb_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tickOut) |-> $past(refStb));
  // R3: rate code 0 is silent
  p_rate0_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rate == '0) |=> !tickOut);
  // R6: counter held at zero while stopped
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> (cnt == '0) && !tickOut);
  // R6: one step per strobe
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && refStb) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R7: no strobe, no change, whatever the rate does
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && !refStb) |=> $stable(cnt));
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refStb,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  output logic [CFG_W-1:0] cfgQ,
  output logic             tickOut
);
  divCtrl_t ctrl;

  rtc_rate_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgData (cfgData),
    .cfgQ    (cfgQ),
    .ctrl    (ctrl)
  );

  rtc_rate_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refStb  (refStb),
    .ctrl    (ctrl),
    .tickOut (tickOut)
  );
endmodule

// File: tb/test_rtc_rate_div.sv
module test_rtc_rate_div;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refStb = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic [7:0] cfgQ;
  logic       tickOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the requirements
  int mCnt = 0;
  int mRate = 6;
  int mDsel = 2;
  int writePulses = 0;
  int widthErrs = 0;

  always #2 clk = ~clk;

  rtc_rate_div i_rtc_rate_div (
    .clk(clk), .rstN(rstN), .refStb(refStb), .cfgWe(cfgWe),
    .cfgData(cfgData), .cfgQ(cfgQ), .tickOut(tickOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgData = d;
    if (tickOut) writePulses++;
    @(negedge clk);
    cfgWe = 1'b0;
    if (tickOut) writePulses++;
    mRate = int'(d[3:0]);
    mDsel = int'(d[6:4]);
    if (mDsel != 2) mCnt = 0;
  endtask

  // run n strobes; report mismatches and ticks seen
  task automatic runStrobes(input int n, output int mism, output int ticks);
    mism = 0; ticks = 0;
    for (int i = 0; i < n; i++) begin
      bit expT;
      expT = 1'b0;
      if (mDsel == 2) begin
        if (mRate != 0) expT = ((mCnt + 1) % (1 << (mRate - 1))) == 0;
        mCnt = (mCnt + 1) % 32768;
      end
      @(negedge clk); refStb = 1'b1;
      @(negedge clk); refStb = 1'b0;
      if (tickOut) ticks++;
      if (tickOut != expT) mism++;
      @(negedge clk);
      if (tickOut) widthErrs++;
    end
  endtask

  task automatic t_reset();
    check(cfgQ == 8'h26, "R1 reset byte", int'(cfgQ), 8'h26);
    check(tickOut == 1'b0, "R1 reset tick", int'(tickOut), 0);
  endtask

  task automatic t_default();
    int m, t;
    runStrobes(64, m, t);
    check(m == 0, "R4 default period 32 phase", m, 0);
    check(t == 2, "R1 R4 default 1024 Hz count", t, 2);
  endtask

  task automatic t_rate1();
    int m, t;
    writeCfg(8'h21);
    check(cfgQ == 8'h21, "R2 write visible", int'(cfgQ), 8'h21);
    runStrobes(5, m, t);
    check(t == 5 && m == 0, "R4 code 1 every strobe", t, 5);
  endtask

  task automatic t_rate0();
    int m, t;
    writeCfg(8'h20);
    runStrobes(40, m, t);
    check(t == 0, "R3 code 0 silent", t, 0);
  endtask

  task automatic t_change();
    int m, t;
    writePulses = 0;
    writeCfg(8'h23);
    check(writePulses == 0, "R7 no pulse on write", writePulses, 0);
    runStrobes(8, m, t);
    check(m == 0, "R7 boundary of running count", m, 0);
    check(t == 2, "R7 tick count after change", t, 2);
  endtask

  task automatic t_dsel();
    int m, t;
    writeCfg(8'h13);
    runStrobes(20, m, t);
    check(t == 0, "R6 stopped divider silent", t, 0);
    writeCfg(8'h23);
    runStrobes(3, m, t);
    check(t == 0, "R6 restart from zero early", t, 0);
    runStrobes(1, m, t);
    check(t == 1, "R6 restart from zero boundary", t, 1);
  endtask

  task automatic t_bit7();
    writeCfg(8'hA6);
    check(cfgQ == 8'h26, "R2 bit 7 ignored", int'(cfgQ), 8'h26);
  endtask

  task automatic t_rate15();
    int m, t;
    writeCfg(8'h2F);
    runStrobes(16384 - mCnt, m, t);
    check(m == 0 && t == 1, "R4 code 15 period 16384", t, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_rate1();
    t_rate0();
    t_change();
    t_dsel();
    t_bit7();
    t_rate15();
    check(widthErrs == 0, "R5 one cycle wide", widthErrs, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule